// File: doc/BRIEF.md
# Stopwatch Direct Key Controller

This block connects two external key pins to the start/stop and lap controls of a stopwatch timer, so a user can run, halt and lap the timer with no software involvement. Software configures it through a small register port with three control fields: a direct-mode enable, a swap bit that chooses which pin drives which function, and a 3-bit mask selector. The mask selector names a group of other key lines. While any key in that group is held, presses on the two direct keys are discarded.

A rising edge on the start/stop key produces a one-cycle toggle pulse, and a rising edge on the lap key produces a one-cycle capture pulse. All key lines and the slow 1024 Hz reference are taken through a two-flop synchronizer first. A change to the enable field waits for the next falling edge of the 1024 Hz reference before it applies. A write-only clear strobe produces a one-cycle counter clear. The clear leaves the run/stop state as it is, so a running stopwatch restarts from zero and a stopped one holds zero. It never fires a lap capture, so a held lap value survives the clear.

Top module: `swkey_ctrl`

## Requirements
- R1: While reset is asserted, all outputs are 0 and every register address reads 0.
- R2: Address 0 holds the enable in bit 0 and the swap in bit 1. Address 1 holds the mask selector in bits 2:0. Both read back their written values, and the unused bits read 0. Address 2 (clear) and address 3 always read 0.
- R3: A write to the enable field takes effect only at the next falling edge of `tick_1k`, measured after the 2-flop synchronizer. Presses before that edge follow the old enable state.
- R4: While the applied enable is 0, key presses produce no `run_tgl` and no `lap_cap`.
- R5: With swap 0, `key_a` is start/stop and `key_b` is lap. With swap 1, `key_a` is lap and `key_b` is start/stop.
- R6: Each rising key edge gives exactly one single-cycle pulse. The pulse is high in the third clock after the first edge that samples the new key level.
- R7: The mask selector picks which `mask_keys` bits are masking: 0 none, 1 {0}, 2 {0,1}, 3 {0,1,2}, 4 {2}, 5 {2,3}, 6 {2,3,4}, 7 {2,3,4,5}. Keys outside the group have no effect.
- R8: A direct-key press whose rising edge falls while any selected mask key is held is discarded. It is not delivered after the mask key is released.
- R9: Writing 1 to bit 0 of address 2 gives a one-cycle `cnt_clr` in the clock after the write. Writing 0 gives nothing.
- R10: `sw_running` toggles on each `run_tgl`. `cnt_clr` leaves `sw_running` unchanged and never causes `lap_cap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| key_a | input | 1 | Direct key pin A, active-high, debounced |
| key_b | input | 1 | Direct key pin B, active-high, debounced |
| mask_keys | input | 6 | Other key lines usable as masking keys |
| tick_1k | input | 1 | 1024 Hz reference level |
| run_tgl | output | 1 | One-cycle start/stop toggle pulse |
| lap_cap | output | 1 | One-cycle lap capture pulse |
| cnt_clr | output | 1 | One-cycle stopwatch counter clear |
| sw_running | output | 1 | Current run/stop state |

## Verification
A wrong applied-enable flag stays hidden until the next direct key press. The press then gives a missing or extra pulse three clocks after its edge. For that reason the bench presses keys both before and after a reference falling edge. If the mask decode or the swap routing is wrong, a pulse appears on the wrong output, or on one that should stay quiet, in that same third cycle. The bench therefore covers every selector value against every mask line. A corrupted run/stop flag or a bad clear strobe shows up on `sw_running` or `cnt_clr` within one clock, and the reference model compares these on every cycle.

// File: rtl/swkey_pkg.sv
package swkey_pkg;

  localparam int MASK_KEYS = 6;
  localparam int SEL_W     = 3;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_MASK = 2'd1,
    RA_CLR  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [SEL_W-1:0] mask_sel;
    logic             swap;
    logic             enable;
  } ctrl_t;

  // Masking group for each selector value (R7)
  function automatic logic [MASK_KEYS-1:0] mask_group(input logic [SEL_W-1:0] sel);
    logic [MASK_KEYS-1:0] g;
    g = '0;
    case (sel)
      3'd1: g[0]   = 1'b1;
      3'd2: g[1:0] = 2'b11;
      3'd3: g[2:0] = 3'b111;
      3'd4: g[2]   = 1'b1;
      3'd5: g[3:2] = 2'b11;
      3'd6: g[4:2] = 3'b111;
      3'd7: g[5:2] = 4'b1111;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/swkey_sync.sv
module swkey_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[LAST];

endmodule

// File: rtl/swkey_regs.sv
module swkey_regs
  import swkey_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             ctrl,
  output logic              clr_pulse
);

  ctrl_t ctrl_q, ctrl_d;
  logic  clr_q, clr_d;

  always_comb begin
    ctrl_d = ctrl_q;
    clr_d  = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_CTRL: begin
          ctrl_d.enable = wr_data[0];
          ctrl_d.swap   = wr_data[1];
        end
        RA_MASK: ctrl_d.mask_sel = wr_data[SEL_W-1:0];
        RA_CLR:  clr_d = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      clr_q  <= clr_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      RA_CTRL: rd_data[1:0]       = {ctrl_q.swap, ctrl_q.enable};
      RA_MASK: rd_data[SEL_W-1:0] = ctrl_q.mask_sel;
      default: rd_data = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign clr_pulse = clr_q;

  // R9
  clr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(wr_en && wr_addr == RA_CLR && wr_data[0]));

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_CLR && wr_data[0]) |=> clr_q);

endmodule

// File: rtl/swkey_gate.sv
module swkey_gate
  import swkey_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_t                ctrl,
  input  logic                 pin_a,
  input  logic                 pin_b,
  input  logic [MASK_KEYS-1:0] mask_in,
  input  logic                 tick_in,
  output logic                 run_tgl,
  output logic                 lap_cap
);

  logic en_act_q, tick_prev_q, prev_a_q, prev_b_q;
  logic run_q, lap_q, run_d, lap_d;
  logic tick_fall, rise_a, rise_b, rise_run, rise_lap, masked;

  always_comb begin
    tick_fall = tick_prev_q & ~tick_in;
    rise_a    = pin_a & ~prev_a_q;
    rise_b    = pin_b & ~prev_b_q;
    if (ctrl.swap) begin
      rise_run = rise_b;
      rise_lap = rise_a;
    end else begin
      rise_run = rise_a;
      rise_lap = rise_b;
    end
    masked = |(mask_in & mask_group(ctrl.mask_sel));
    run_d  = en_act_q & rise_run & ~masked;
    lap_d  = en_act_q & rise_lap & ~masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_act_q    <= 1'b0;
      tick_prev_q <= 1'b0;
      prev_a_q    <= 1'b0;
      prev_b_q    <= 1'b0;
      run_q       <= 1'b0;
      lap_q       <= 1'b0;
    end else begin
      if (tick_fall) begin
        en_act_q <= ctrl.enable;
      end
      tick_prev_q <= tick_in;
      prev_a_q    <= pin_a;
      prev_b_q    <= pin_b;
      run_q       <= run_d;
      lap_q       <= lap_d;
    end
  end

  assign run_tgl = run_q;
  assign lap_cap = lap_q;

  // R3
  enable_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_fall) |-> $stable(en_act_q));

  // R4
  no_pulse_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q || lap_q) |-> $past(en_act_q));

  // R6
  run_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> !run_q);

  // R6
  lap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lap_q |=> !lap_q);

  // R8
  masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q || lap_q) |-> $past(!masked));

endmodule

// File: rtl/swkey_ctrl.sv
module swkey_ctrl
  import swkey_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              key_a,
  input  logic              key_b,
  input  logic [5:0]        mask_keys,
  input  logic              tick_1k,
  output logic              run_tgl,
  output logic              lap_cap,
  output logic              cnt_clr,
  output logic              sw_running
);

  localparam int SYNC_W = MASK_KEYS + 3;

  ctrl_t                ctrl;
  logic                 clr_pulse;
  logic [SYNC_W-1:0]    raw_bus, sync_bus;
  logic [MASK_KEYS-1:0] mask_s;
  logic                 a_s, b_s, tick_s;
  logic                 run_w, lap_w;
  logic                 running_q, running_d;

  assign raw_bus = {mask_keys, tick_1k, key_b, key_a};
  assign a_s     = sync_bus[0];
  assign b_s     = sync_bus[1];
  assign tick_s  = sync_bus[2];
  assign mask_s  = sync_bus[SYNC_W-1:3];

  swkey_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ctrl      (ctrl),
    .clr_pulse (clr_pulse)
  );

  swkey_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  swkey_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .pin_a   (a_s),
    .pin_b   (b_s),
    .mask_in (mask_s),
    .tick_in (tick_s),
    .run_tgl (run_w),
    .lap_cap (lap_w)
  );

  always_comb begin
    running_d = running_q ^ run_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
    end else begin
      running_q <= running_d;
    end
  end

  assign run_tgl    = run_w;
  assign lap_cap    = lap_w;
  assign cnt_clr    = clr_pulse;
  assign sw_running = running_q;

  // R10
  clr_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !run_tgl) |=> $stable(sw_running));

  // R10
  toggle_flips_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_tgl |=> (sw_running != $past(sw_running)));

endmodule

// File: tb/sim_swkey_ctrl.sv
module sim_swkey_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       key_a, key_b, tick_1k;
  logic [5:0] mask_keys;
  logic       run_tgl, lap_cap, cnt_clr, sw_running;

  int total = 0, bad = 0;
  int run_seen = 0, lap_seen = 0, clr_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swkey_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .key_a(key_a), .key_b(key_b),
    .mask_keys(mask_keys), .tick_1k(tick_1k), .run_tgl(run_tgl), .lap_cap(lap_cap),
    .cnt_clr(cnt_clr), .sw_running(sw_running)
  );

  // group from the requirement table: start line and length
  function automatic logic [5:0] grp_of(input logic [2:0] sel);
    logic [5:0] g;
    int first, len;
    g = '0;
    if (sel != 0) begin
      first = sel[2] ? 2 : 0;
      len   = sel[2] ? (int'(sel[1:0]) + 1) : int'(sel[1:0]);
      for (int i = 0; i < len; i++) g[first + i] = 1'b1;
    end
    return g;
  endfunction

  // reference model state
  logic       m_en, m_sw, m_act, m_run, m_lap, m_clr, m_running;
  logic [2:0] m_sel;
  logic       a1, a2, a3, b1, b2, b3, t1, t2, t3;
  logic [5:0] k1, k2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sw = 0; m_act = 0; m_run = 0; m_lap = 0; m_clr = 0; m_running = 0;
      m_sel = 0;
      a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0; t1 = 0; t2 = 0; t3 = 0;
      k1 = 0; k2 = 0;
    end else begin : model_step
      logic ra, rb, blk, fall;
      ra   = a2 & ~a3;
      rb   = b2 & ~b3;
      blk  = |(k2 & grp_of(m_sel));
      fall = t3 & ~t2;
      if (m_run) m_running = ~m_running;
      m_run = m_act & (m_sw ? rb : ra) & ~blk;
      m_lap = m_act & (m_sw ? ra : rb) & ~blk;
      if (fall) m_act = m_en;
      m_clr = wr_en && wr_addr == 2'd2 && wr_data[0];
      if (wr_en && wr_addr == 2'd0) begin m_en = wr_data[0]; m_sw = wr_data[1]; end
      if (wr_en && wr_addr == 2'd1) m_sel = wr_data[2:0];
      a3 = a2; a2 = a1; a1 = key_a;
      b3 = b2; b2 = b1; b1 = key_b;
      t3 = t2; t2 = t1; t1 = tick_1k;
      k2 = k1; k1 = mask_keys;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp_v, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {6'b0, m_sw, m_en};
      2'd1:    return {5'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(run_tgl === m_run, "R6 run_tgl", run_tgl, m_run);
      chk(lap_cap === m_lap, "R5 lap_cap", lap_cap, m_lap);
      chk(cnt_clr === m_clr, "R9 cnt_clr", cnt_clr, m_clr);
      chk(sw_running === m_running, "R10 sw_running", sw_running, m_running);
      chk(rd_data === exp_rd(rd_addr), "R2 rd_data", rd_data, exp_rd(rd_addr));
      run_seen += int'(run_tgl);
      lap_seen += int'(lap_cap);
      clr_seen += int'(cnt_clr);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic zero_counts();
    run_seen = 0; lap_seen = 0; clr_seen = 0;
  endtask

  task automatic expect_counts(input int er, input int el, input string tag);
    chk(run_seen == er, {tag, " run count"}, run_seen, er);
    chk(lap_seen == el, {tag, " lap count"}, lap_seen, el);
  endtask

  task automatic press_a();
    key_a = 1'b1; step(6); key_a = 1'b0; step(6);
  endtask

  task automatic press_b();
    key_b = 1'b1; step(6); key_b = 1'b0; step(6);
  endtask

  task automatic tick_fall_now();
    tick_1k = 1'b1; step(4); tick_1k = 1'b0; step(6);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    key_a = 0; key_b = 0; mask_keys = 0; tick_1k = 0;
    step(3);
    // R1: outputs and read-back during reset
    chk({run_tgl, lap_cap, cnt_clr, sw_running} === 4'b0, "R1 outputs in reset",
        {run_tgl, lap_cap, cnt_clr, sw_running}, 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk(rd_data === 8'h00, "R1 read in reset", rd_data, 0);
    end
    rd_addr = 0;
    rst_n = 1'b1;
    step(3);

    // R2: read-back
    wr(2'd0, 8'hFF); rd_addr = 2'd0; #1;
    chk(rd_data === 8'h03, "R2 ctrl readback", rd_data, 8'h03);
    wr(2'd1, 8'hFD); rd_addr = 2'd1; #1;
    chk(rd_data === 8'h05, "R2 mask readback", rd_data, 8'h05);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    rd_addr = 2'd0;

    // R3: enable pending until a reference falling edge
    wr(2'd0, 8'h01);
    zero_counts(); press_a(); press_b();
    expect_counts(0, 0, "R3 before fall");
    tick_fall_now();
    zero_counts(); press_a(); press_b();
    expect_counts(1, 1, "R3 after fall");

    // R5: swapped routing
    wr(2'd0, 8'h03);
    zero_counts(); press_a();
    expect_counts(0, 1, "R5 swap a->lap");
    zero_counts(); press_b();
    expect_counts(1, 0, "R5 swap b->run");
    wr(2'd0, 8'h01);

    // R6: long hold yields a single pulse
    zero_counts(); key_a = 1'b1; step(30); key_a = 1'b0; step(6);
    expect_counts(1, 0, "R6 long hold");

    // R7: every selector against every mask line
    rd_addr = 2'd1;
    for (int s = 0; s < 8; s++) begin
      wr(2'd1, 8'(s));
      for (int j = 0; j < 6; j++) begin
        logic [5:0] g;
        g = grp_of(3'(s));
        zero_counts();
        mask_keys = 6'(1 << j); step(4);
        press_a();
        mask_keys = '0; step(4);
        expect_counts(g[j] ? 0 : 1, 0, "R7 mask group");
      end
    end

    // R8: press under mask is discarded, not deferred
    wr(2'd1, 8'h01);
    zero_counts();
    mask_keys = 6'b000001; step(4);
    key_a = 1'b1; step(5);
    mask_keys = '0; step(8);
    key_a = 1'b0; step(6);
    expect_counts(0, 0, "R8 dropped press");
    zero_counts(); press_a();
    expect_counts(1, 0, "R8 after release");
    wr(2'd1, 8'h00);

    // R9 / R10: clear strobe
    rd_addr = 2'd2;
    begin : clr_blk
      logic run_before;
      run_before = sw_running;
      zero_counts(); wr(2'd2, 8'h01); step(3);
      chk(clr_seen == 1, "R9 clear once", clr_seen, 1);
      chk(sw_running === run_before, "R10 run kept", sw_running, run_before);
      expect_counts(0, 0, "R10 no lap on clear");
      zero_counts(); wr(2'd2, 8'h00); step(3);
      chk(clr_seen == 0, "R9 write zero", clr_seen, 0);
      chk(rd_data === 8'h00, "R9 clear reads 0", rd_data, 0);
    end

    // R4: disabled after next fall
    wr(2'd0, 8'h00);
    tick_fall_now();
    zero_counts(); press_a(); press_b();
    expect_counts(0, 0, "R4 disabled");

    step(4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule